// File: doc/BRIEF.md
# Power-Mode Supervisor

This block is the central mode controller of a system-basis device. It keeps the device in one of six modes and moves between them. The inputs are decoded SPI write commands, an any-frame strobe, wake events from the buses and from a wake pin, a level that says wake flags are still pending, a watchdog failure, supply undervoltage, overvoltage and short events, a thermal shutdown level and a millisecond tick. From the mode it drives the reset output, the main regulator enable, the buck PWM/PFM select, a sticky SPI-fail flag and the fail-output activation.

Faults have a fixed priority. Thermal shutdown or a supply short sends the device to fail-safe. A reset-class fault (undervoltage, overvoltage when that reset is enabled, or a watchdog failure) sends it to restart. Software requests are acted on only when neither kind of fault is present. Restart returns to normal on its own once a tick-counted reset delay has passed with no fault present. Fail-safe holds for a minimum dwell whose length depends on the cause. A wake that arrives during the dwell is stored and acted on when the dwell ends.

All control inputs are plain single-cycle levels or strobes. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `pwr_mode_sup`

## Requirements
- R1: After reset the mode output is 0 (init), the reset output is high, the regulator is enabled, PWM is selected, and SPI-fail and the fail output are low. Any SPI frame strobe in init moves the mode to 1 (normal). Mode codes: 0 init, 1 normal, 2 stop, 3 sleep, 4 restart, 5 fail-safe.
- R2: Bus or pin wake events in init leave the mode at init and are not remembered.
- R3: In stop, a go-to-sleep write (kind 2) sets SPI-fail and moves the mode to restart.
- R4: In stop, write kinds are handled as follows:
  - go-normal (kind 0) moves to normal;
  - soft reset (kind 3) moves to init;
  - watchdog refresh (kind 4) and status clear (kind 5) are accepted without error, and status clear also clears SPI-fail;
  - go-stop (kind 1) and config writes (kind 6) set SPI-fail and leave the mode unchanged.
- R5: In normal, a go-sleep write with no pending wake flags enters sleep. Sleep drives the reset output low and turns the regulator off. With flags pending, the same write goes to restart instead. Writes received in sleep are ignored.
- R6: Restart is entered:
  - from normal or stop on undervoltage, on overvoltage only while the overvoltage-reset enable is high, or on watchdog failure;
  - from init on watchdog failure;
  - from sleep on a bus or pin wake.
  A watchdog failure also raises the fail output.
- R7: Restart holds the reset output low. It moves to normal one cycle after RST_DLY_MS ticks have been counted. The count restarts from zero while undervoltage is present.
- R8: Thermal shutdown or a supply short moves the device to fail-safe from any other mode. Fail-safe turns the regulator off, holds the reset output low and raises the fail output. The fail output stays high after fail-safe is left.
- R9: Fail-safe holds for at least FS_TSD_MS ticks after a thermal cause, or FS_OTHER_MS ticks after a short. A wake seen during the dwell is stored and moves the device to restart when the dwell ends. Fail-safe is not left while thermal shutdown is still present.
- R10: PWM is selected in init, normal and restart. PFM is selected in stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| spi_frame | input | 1 | Strobe: any SPI frame received |
| wr_valid | input | 1 | Strobe: decoded SPI write present |
| wr_kind | input | 3 | Write kind: 0 go-normal, 1 go-stop, 2 go-sleep, 3 soft reset, 4 watchdog refresh, 5 status clear, 6 config |
| wake_bus | input | 1 | Bus wake event |
| wake_pin | input | 1 | Pin wake event |
| wake_pending | input | 1 | Wake-source flags not yet cleared |
| wd_fail | input | 1 | Watchdog failure event |
| vcc_uv | input | 1 | Supply undervoltage |
| vcc_ov | input | 1 | Supply overvoltage |
| ov_rst_en | input | 1 | Overvoltage causes restart when high |
| vcc_short | input | 1 | Supply short to ground |
| tsd | input | 1 | Thermal shutdown level |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| mode_o | output | 3 | Current mode code |
| rst_out_n | output | 1 | Reset output, active low |
| reg_en | output | 1 | Main regulator enable |
| buck_pwm | output | 1 | 1 PWM, 0 PFM |
| spi_fail | output | 1 | Sticky illegal-write flag |
| fo_active | output | 1 | Fail-output activation |

## Verification
The bench sweeps every write kind while the device is in stop and compares the resulting mode and SPI-fail against a table it computes. A design that accepted stop-to-sleep directly would show mode 3 with no error flag. A design that let exempt writes through as errors would raise SPI-fail on a watchdog refresh. Sleep entry is tried both with wake flags pending and without; a design that ignored the pending level would sit in sleep with wakes already lost. The restart delay and both fail-safe dwell lengths are checked one tick short of expiry and exactly at expiry. Further cases cover a wake stored mid-dwell, a thermal level still present at dwell end, and undervoltage restarting the delay count. A design with an off-by-one counter, a single shared dwell length, or an unstored wake would either leave too early or hang in fail-safe.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    M_INIT     = 3'd0,
    M_NORMAL   = 3'd1,
    M_STOP     = 3'd2,
    M_SLEEP    = 3'd3,
    M_RESTART  = 3'd4,
    M_FAILSAFE = 3'd5
  } mode_e;

  typedef enum logic [2:0] {
    W_GO_NORMAL  = 3'd0,
    W_GO_STOP    = 3'd1,
    W_GO_SLEEP   = 3'd2,
    W_SOFT_RST   = 3'd3,
    W_WD_REFRESH = 3'd4,
    W_STAT_CLEAR = 3'd5,
    W_CONFIG     = 3'd6
  } wr_kind_e;
endpackage

// File: rtl/pwr_tick_timer.sv
module pwr_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (clear)                 cnt <= '0;
    else if (tick && (cnt < limit)) cnt <= cnt + 1'b1;
  end

  assign done = (cnt >= limit);

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && tick && !done) |=> (cnt == $past(cnt) + 1'b1)); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0)); // R9
endmodule

// File: rtl/pwr_wake_store.sv
module pwr_wake_store (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic wake,
  output logic stored
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stored <= 1'b0;
    else if (arm) stored <= stored | wake;
    else          stored <= 1'b0;
  end

  AST_WAKE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && stored && $past(arm)) |-> $past(stored) || $past(wake)); // R9
endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
  import pwr_mode_pkg::*;
(
  input  mode_e st,
  output logic  rst_out_n,
  output logic  reg_en,
  output logic  buck_pwm
);
  always_comb begin
    rst_out_n = 1'b1;
    reg_en    = 1'b1;
    buck_pwm  = 1'b0;
    unique case (st)
      M_INIT, M_NORMAL: buck_pwm = 1'b1;
      M_STOP:           buck_pwm = 1'b0;
      M_RESTART: begin
        rst_out_n = 1'b0;
        buck_pwm  = 1'b1;
      end
      M_SLEEP, M_FAILSAFE: begin
        rst_out_n = 1'b0;
        reg_en    = 1'b0;
      end
      default: begin
        rst_out_n = 1'b0;
        reg_en    = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pwr_mode_sup.sv
module pwr_mode_sup
  import pwr_mode_pkg::*;
#(
  parameter int RST_DLY_MS  = 10,
  parameter int FS_TSD_MS   = 1000,
  parameter int FS_OTHER_MS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_frame,
  input  logic       wr_valid,
  input  logic [2:0] wr_kind,
  input  logic       wake_bus,
  input  logic       wake_pin,
  input  logic       wake_pending,
  input  logic       wd_fail,
  input  logic       vcc_uv,
  input  logic       vcc_ov,
  input  logic       ov_rst_en,
  input  logic       vcc_short,
  input  logic       tsd,
  input  logic       ms_tick,
  output logic [2:0] mode_o,
  output logic       rst_out_n,
  output logic       reg_en,
  output logic       buck_pwm,
  output logic       spi_fail,
  output logic       fo_active
);
  localparam int FS_MAX = (FS_TSD_MS > FS_OTHER_MS) ? FS_TSD_MS : FS_OTHER_MS;
  localparam int FW     = $clog2(FS_MAX + 1);
  localparam int RW     = $clog2(RST_DLY_MS + 1);

  mode_e    st, nxt;
  wr_kind_e kind;
  logic fs_cause, rst_fault, wake_now;
  logic set_fail, clr_fail, fo_set;
  logic fs_thermal, rst_done, fs_done, wake_stored;
  logic [FW-1:0] fs_limit;

  assign kind      = wr_kind_e'(wr_kind);
  assign fs_cause  = tsd | vcc_short;
  assign rst_fault = vcc_uv | (vcc_ov & ov_rst_en);
  assign wake_now  = wake_bus | wake_pin;
  assign fs_limit  = fs_thermal ? FW'(FS_TSD_MS) : FW'(FS_OTHER_MS);

  always_comb begin
    nxt      = st;
    set_fail = 1'b0;
    clr_fail = wr_valid && (kind == W_STAT_CLEAR) &&
               (st == M_NORMAL || st == M_STOP);
    unique case (st)
      M_INIT: begin
        if (fs_cause)              nxt = M_FAILSAFE;
        else if (wd_fail | vcc_uv) nxt = M_RESTART;
        else if (spi_frame)        nxt = M_NORMAL;
      end
      M_NORMAL: begin
        if (fs_cause)                  nxt = M_FAILSAFE;
        else if (rst_fault | wd_fail)  nxt = M_RESTART;
        else if (wr_valid) begin
          case (kind)
            W_GO_STOP:  nxt = M_STOP;
            W_GO_SLEEP: nxt = wake_pending ? M_RESTART : M_SLEEP;
            W_SOFT_RST: nxt = M_INIT;
            default:    nxt = M_NORMAL;
          endcase
        end
      end
      M_STOP: begin
        if (fs_cause)                  nxt = M_FAILSAFE;
        else if (rst_fault | wd_fail)  nxt = M_RESTART;
        else if (wr_valid) begin
          case (kind)
            W_GO_NORMAL:  nxt = M_NORMAL;
            W_SOFT_RST:   nxt = M_INIT;
            W_GO_SLEEP: begin
              nxt      = M_RESTART;
              set_fail = 1'b1;
            end
            W_WD_REFRESH, W_STAT_CLEAR: nxt = M_STOP;
            default:      set_fail = 1'b1;
          endcase
        end
      end
      M_SLEEP: begin
        if (fs_cause)      nxt = M_FAILSAFE;
        else if (wake_now) nxt = M_RESTART;
      end
      M_RESTART: begin
        if (fs_cause)                   nxt = M_FAILSAFE;
        else if (rst_done && !rst_fault) nxt = M_NORMAL;
      end
      M_FAILSAFE: begin
        if (fs_done && (wake_stored || wake_now) && !fs_cause) nxt = M_RESTART;
      end
      default: nxt = M_INIT;
    endcase
  end

  assign fo_set = ((nxt == M_FAILSAFE) && (st != M_FAILSAFE)) ||
                  (wd_fail && (st == M_INIT || st == M_NORMAL || st == M_STOP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= M_INIT;
      spi_fail   <= 1'b0;
      fo_active  <= 1'b0;
      fs_thermal <= 1'b0;
    end else begin
      st <= nxt;
      if (set_fail)      spi_fail <= 1'b1;
      else if (clr_fail) spi_fail <= 1'b0;
      if (fo_set) fo_active <= 1'b1;
      if ((st != M_FAILSAFE) && (nxt == M_FAILSAFE)) fs_thermal <= tsd;
    end
  end

  pwr_tick_timer #(.W(RW)) u_rst_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .clear ((st != M_RESTART) | rst_fault),
    .tick  (ms_tick),
    .limit (RW'(RST_DLY_MS)),
    .done  (rst_done)
  );

  pwr_tick_timer #(.W(FW)) u_fs_dwell (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (st != M_FAILSAFE),
    .tick  (ms_tick),
    .limit (fs_limit),
    .done  (fs_done)
  );

  pwr_wake_store u_wake (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (st == M_FAILSAFE),
    .wake   (wake_now),
    .stored (wake_stored)
  );

  pwr_out_decode u_out (
    .st        (st),
    .rst_out_n (rst_out_n),
    .reg_en    (reg_en),
    .buck_pwm  (buck_pwm)
  );

  assign mode_o = st;

  AST_INIT_WAKE_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_INIT && wake_now && !spi_frame && !wd_fail && !vcc_uv && !fs_cause)
    |=> (st == M_INIT)); // R2
  AST_STOP_SLEEP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_STOP && wr_valid && kind == W_GO_SLEEP && !fs_cause && !rst_fault && !wd_fail)
    |=> (st == M_RESTART && spi_fail)); // R3
  AST_RESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_RESTART || st == M_SLEEP || st == M_FAILSAFE) |-> !rst_out_n); // R5
  AST_RESTART_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_RESTART) |=> (st == M_RESTART || st == M_NORMAL || st == M_FAILSAFE)); // R7
  AST_FS_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_FAILSAFE) |-> (!reg_en && fo_active)); // R8
  AST_FS_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_FAILSAFE && !fs_done) |=> (st == M_FAILSAFE)); // R9
  AST_STOP_PFM: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_STOP) |-> !buck_pwm); // R10
endmodule

// File: tb/pwr_mode_sup_test.sv
module pwr_mode_sup_test;
  localparam int RD = 3, FT = 6, FO = 4;

  logic clk = 0, rst_n = 0;
  logic spi_frame = 0, wr_valid = 0;
  logic [2:0] wr_kind = 0;
  logic wake_bus = 0, wake_pin = 0, wake_pending = 0, wd_fail = 0;
  logic vcc_uv = 0, vcc_ov = 0, ov_rst_en = 0, vcc_short = 0, tsd = 0, ms_tick = 0;
  logic [2:0] mode_o;
  logic rst_out_n, reg_en, buck_pwm, spi_fail, fo_active;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pwr_mode_sup #(.RST_DLY_MS(RD), .FS_TSD_MS(FT), .FS_OTHER_MS(FO)) uut (
    .clk(clk), .rst_n(rst_n), .spi_frame(spi_frame), .wr_valid(wr_valid),
    .wr_kind(wr_kind), .wake_bus(wake_bus), .wake_pin(wake_pin),
    .wake_pending(wake_pending), .wd_fail(wd_fail), .vcc_uv(vcc_uv),
    .vcc_ov(vcc_ov), .ov_rst_en(ov_rst_en), .vcc_short(vcc_short), .tsd(tsd),
    .ms_tick(ms_tick), .mode_o(mode_o), .rst_out_n(rst_out_n), .reg_en(reg_en),
    .buck_pwm(buck_pwm), .spi_fail(spi_fail), .fo_active(fo_active));

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(int k);
    wr_valid = 1; wr_kind = 3'(k); @(negedge clk); wr_valid = 0;
  endtask

  task automatic frame();
    spi_frame = 1; @(negedge clk); spi_frame = 0;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1; @(negedge clk); ms_tick = 0;
    end
  endtask

  task automatic wake();
    wake_bus = 1; @(negedge clk); wake_bus = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; cyc(2); rst_n = 1; cyc(1);
  endtask

  task automatic to_normal();
    for (int i = 0; i < 40 && mode_o != 3'd1; i++) begin
      if (mode_o == 3'd0) frame();
      else if (mode_o == 3'd4) tick(1);
      else cyc(1);
    end
    wr(5);
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 reset mode", mode_o, 0);
    chk("R1 reset rst_out", rst_out_n, 1);
    chk("R1 reset reg_en", reg_en, 1);
    chk("R1 reset fail flags", {spi_fail, fo_active}, 0);
    chk("R10 init pwm", buck_pwm, 1);

    wake_bus = 1; wake_pin = 1; cyc(1); wake_bus = 0; wake_pin = 0; cyc(2);
    chk("R2 wake in init ignored", mode_o, 0);
    frame();
    chk("R1 frame to normal", mode_o, 1);
    chk("R2 no wake remembered", mode_o, 1);
    chk("R10 normal pwm", buck_pwm, 1);

    // R3 R4 sweep over write kinds while in stop
    for (int k = 0; k < 7; k++) begin
      int em, ef;
      to_normal();
      wr(1);
      chk("R10 stop pfm", {mode_o, buck_pwm}, {3'd2, 1'b0});
      case (k)
        0: begin em = 1; ef = 0; end
        1: begin em = 2; ef = 1; end
        2: begin em = 4; ef = 1; end
        3: begin em = 0; ef = 0; end
        6: begin em = 2; ef = 1; end
        default: begin em = 2; ef = 0; end
      endcase
      wr(k);
      chk((k == 2) ? "R3 stop sleep mode" : "R4 stop write mode", mode_o, em);
      chk((k == 2) ? "R3 stop sleep fail" : "R4 stop write fail", spi_fail, ef);
      if (k == 6) begin
        wr(5);
        chk("R4 status clear in stop", {mode_o, spi_fail}, {3'd2, 1'b0});
      end
    end

    // R5 sleep entry
    to_normal();
    wake_pending = 1; wr(2); wake_pending = 0;
    chk("R5 pending flags to restart", mode_o, 4);
    to_normal();
    wr(2);
    chk("R5 sleep entered", mode_o, 3);
    chk("R5 sleep outputs", {rst_out_n, reg_en}, 0);
    wr(0); cyc(1);
    chk("R5 write in sleep ignored", mode_o, 3);

    // R6 wake from sleep, R7 restart delay
    wake();
    chk("R6 sleep wake to restart", mode_o, 4);
    chk("R7 restart reset low", rst_out_n, 0);
    chk("R10 restart pwm", buck_pwm, 1);
    tick(RD - 1); cyc(2);
    chk("R7 held one tick short", mode_o, 4);
    tick(1); cyc(1);
    chk("R7 exit after delay", {mode_o, rst_out_n}, {3'd1, 1'b1});

    vcc_uv = 1; cyc(1);
    chk("R6 undervoltage restart", mode_o, 4);
    tick(RD + 2);
    chk("R7 held during undervoltage", mode_o, 4);
    vcc_uv = 0;
    tick(RD - 1); cyc(1);
    chk("R7 count restarted", mode_o, 4);
    tick(1); cyc(1);
    chk("R7 exit after fault cleared", mode_o, 1);

    vcc_ov = 1; cyc(2);
    chk("R6 overvoltage ignored when disabled", mode_o, 1);
    ov_rst_en = 1; cyc(1);
    chk("R6 overvoltage restart", mode_o, 4);
    vcc_ov = 0; ov_rst_en = 0;
    to_normal(); wr(1);
    vcc_uv = 1; cyc(1); vcc_uv = 0;
    chk("R6 stop undervoltage restart", mode_o, 4);

    // R8 R9 thermal fail-safe with stored wake
    to_normal();
    chk("R8 fo low before", fo_active, 0);
    tsd = 1; cyc(1);
    chk("R8 thermal to failsafe", mode_o, 5);
    chk("R8 failsafe outputs", {reg_en, rst_out_n, fo_active}, 3'b001);
    tsd = 0;
    tick(2); wake(); tick(FT - 3); cyc(2);
    chk("R9 thermal dwell not done", mode_o, 5);
    tick(1); cyc(1);
    chk("R9 stored wake acted on", mode_o, 4);
    to_normal();
    chk("R8 fo stays active", fo_active, 1);

    // R9 short cause: shorter dwell, needs wake
    vcc_short = 1; cyc(1); vcc_short = 0;
    chk("R8 short to failsafe", mode_o, 5);
    tick(FO); cyc(3);
    chk("R9 waits for wake", mode_o, 5);
    wake();
    chk("R9 short dwell wake", mode_o, 4);

    // R9 thermal still present
    to_normal();
    tsd = 1; cyc(1);
    tick(FT); wake(); cyc(2);
    chk("R9 held while thermal", mode_o, 5);
    tsd = 0; cyc(1);
    chk("R9 leaves after thermal gone", mode_o, 4);

    // R8 from init, R6 watchdog from init and normal
    do_reset();
    vcc_short = 1; cyc(1); vcc_short = 0;
    chk("R8 init short to failsafe", mode_o, 5);
    do_reset();
    wd_fail = 1; cyc(1); wd_fail = 0;
    chk("R6 init watchdog restart", {mode_o, fo_active}, {3'd4, 1'b1});
    do_reset(); frame();
    wd_fail = 1; cyc(1); wd_fail = 0;
    chk("R6 normal watchdog restart", {mode_o, fo_active}, {3'd4, 1'b1});

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule